// File: doc/BRIEF.md
# Self-Locking Pseudo-Random Sequence Error Checker

This block receives a serial stream, one bit per clock qualified by a valid strobe, and compares it against one of five maximal-length pseudo-random sequences. It needs no alignment from outside. It fills its local shift register from the first received bits. It then watches a run of predicted bits and decides for itself whether the stream arrives true or complemented. After that it runs its generator freely and flags every bit that differs from the expected value.

While locked, the block keeps a saturating count of checked bits and a saturating count of bit errors. A blanking input keeps chosen bits out of both counts and out of the error strobe. A resynchronization input, or too many errors inside one observation window, sends the block back to acquisition. It is used as the receive half of a link bit-error-rate test, next to a matching sequence generator.

Top module: `prbs_autolock_checker`

## Requirements
- R1: `poly_sel_i` selects the sequence. The encoding is 0 = x^7+x^6+1, 1 = x^9+x^5+1, 2 = x^15+x^14+1, 3 = x^23+x^18+1 and 4 = x^31+x^28+1. Codes 5 to 7 act as code 0. Every selected sequence can be acquired, whether it arrives true or inverted.
- R2: After reset or any return to acquisition, the first ORDER valid bits seed the local register, where ORDER is the polynomial degree. `locked_o` rises right after the LOCK_LEN-th (64) further valid bit, provided every one of those bits equalled its prediction. It is still low one bit earlier.
- R3: If all LOCK_LEN predicted bits mismatch, the block locks with `inverted_o` = 1 and from then on expects the complement of the sequence. If they all match, `inverted_o` = 0.
- R4: A stream that follows neither the selected sequence nor its complement never raises `locked_o`.
- R5: `err_o` is high for exactly the one cycle after a valid, unblanked bit that differs from the expected bit while locked. Each such bit adds one to `err_count_o`.
- R6: While locked, `bit_count_o` adds one for each valid, unblanked bit. Cycles with `valid_i` low change nothing.
- R7: A bit with `blank_i` high produces no `err_o` and changes neither count, even when it is wrong.
- R8: `resync_i` high drops `locked_o` in the next cycle and restarts acquisition. The block then locks again on the continuing stream.
- R9: Lock is kept when up to LOSS_THR-1 (15) unblanked errors fall inside a WIN_LEN (64) valid-bit window that starts at lock. The window restarts after 64 bits. Reaching LOSS_THR (16) errors inside one window drops `locked_o` right after the bit that makes the 16th error.
- R10: Both counters are CNT_W bits wide and stop at their all-ones value.
- R11: While not locked, neither count changes and `err_o` stays low.
- R12: After reset, `locked_o`, `inverted_o` and `err_o` are low and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| poly_sel_i | input | 3 | Sequence select |
| bit_i | input | 1 | Received serial bit |
| valid_i | input | 1 | Qualifies `bit_i` |
| blank_i | input | 1 | Keeps the current bit out of error checking and counting |
| resync_i | input | 1 | Forces a return to acquisition |
| locked_o | output | 1 | Checker is locked to the stream |
| inverted_o | output | 1 | Locked stream is the complement of the sequence |
| err_o | output | 1 | One-cycle strobe for an errored bit |
| bit_count_o | output | CNT_W | Saturating count of checked bits |
| err_count_o | output | CNT_W | Saturating count of errored bits |

## Verification
The bench builds the block with CNT_W = 6 and keeps LOCK_LEN = 64, WIN_LEN = 64 and LOSS_THR = 16. Narrow counters let a few hundred bits push both counts into saturation. At the default width that limit could not be reached. Because the window and threshold keep their default values, the bench checks the exact 15-versus-16 error boundary and the restart of the window after 64 bits.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int unsigned HIST_W = 31;

  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } sync_state_e;

  // Highest feedback tap, which equals the polynomial degree.
  function automatic logic [4:0] tap_hi(input logic [2:0] sel);
    case (sel)
      3'd1:    tap_hi = 5'd9;
      3'd2:    tap_hi = 5'd15;
      3'd3:    tap_hi = 5'd23;
      3'd4:    tap_hi = 5'd31;
      default: tap_hi = 5'd7;
    endcase
  endfunction

  // Second feedback tap.
  function automatic logic [4:0] tap_lo(input logic [2:0] sel);
    case (sel)
      3'd1:    tap_lo = 5'd5;
      3'd2:    tap_lo = 5'd14;
      3'd3:    tap_lo = 5'd18;
      3'd4:    tap_lo = 5'd28;
      default: tap_lo = 5'd6;
    endcase
  endfunction

endpackage

// File: rtl/prbs_predict.sv
module prbs_predict
  import prbs_chk_pkg::*;
(
  input  logic [HIST_W-1:0] hist,
  input  logic [2:0]        sel,
  output logic              pred
);
  logic [4:0] idx_a;
  logic [4:0] idx_b;

  // hist[0] holds the most recent bit, so hist[k-1] is the bit k steps back.
  always_comb begin
    idx_a = tap_hi(sel) - 5'd1;
    idx_b = tap_lo(sel) - 5'd1;
    pred  = hist[idx_a] ^ hist[idx_b];
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (inc && !(&count_q)) count_d = count_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/prbs_sync_ctrl.sv
module prbs_sync_ctrl
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_LEN = 64,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel,
  input  logic        valid,
  input  logic        miss,
  input  logic        blank,
  input  logic        resync,
  output sync_state_e state,
  output logic        inv
);
  localparam int CKW = $clog2(LOCK_LEN);
  localparam int WNW = $clog2(WIN_LEN);
  localparam int EW  = $clog2(LOSS_THR + 1);

  sync_state_e    state_q, state_d;
  logic           inv_q, inv_d;
  logic [4:0]     seed_q, seed_d;
  logic [CKW-1:0] chk_q, chk_d;
  logic           hit_q, hit_d, mis_q, mis_d;
  logic [WNW-1:0] win_q, win_d;
  logic [EW-1:0]  werr_q, werr_d;
  logic           hit_n, mis_n, lock_err;
  logic [EW-1:0]  werr_sum;

  always_comb begin
    state_d  = state_q;
    inv_d    = inv_q;
    seed_d   = seed_q;
    chk_d    = chk_q;
    hit_d    = hit_q;
    mis_d    = mis_q;
    win_d    = win_q;
    werr_d   = werr_q;
    hit_n    = hit_q & ~miss;
    mis_n    = mis_q & miss;
    lock_err = miss ^ inv_q;
    werr_sum = werr_q + EW'(lock_err & ~blank);
    if (resync) begin
      state_d = ST_SEED;
      seed_d  = '0;
      inv_d   = 1'b0;
    end else if (valid) begin
      case (state_q)
        ST_SEED: begin
          if (seed_q == tap_hi(sel) - 5'd1) begin
            state_d = ST_CHECK;
            chk_d   = '0;
            hit_d   = 1'b1;
            mis_d   = 1'b1;
          end else begin
            seed_d = seed_q + 5'd1;
          end
        end
        ST_CHECK: begin
          hit_d = hit_n;
          mis_d = mis_n;
          if (!hit_n && !mis_n) begin
            state_d = ST_SEED;
            seed_d  = '0;
          end else if (chk_q == CKW'(LOCK_LEN - 1)) begin
            state_d = ST_LOCK;
            inv_d   = mis_n;
            win_d   = '0;
            werr_d  = '0;
          end else begin
            chk_d = chk_q + CKW'(1);
          end
        end
        ST_LOCK: begin
          if (werr_sum >= EW'(LOSS_THR)) begin
            state_d = ST_SEED;
            seed_d  = '0;
            inv_d   = 1'b0;
          end else if (win_q == WNW'(WIN_LEN - 1)) begin
            win_d  = '0;
            werr_d = '0;
          end else begin
            win_d  = win_q + WNW'(1);
            werr_d = werr_sum;
          end
        end
        default: begin
          state_d = ST_SEED;
          seed_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEED;
      inv_q   <= 1'b0;
      seed_q  <= '0;
      chk_q   <= '0;
      hit_q   <= 1'b0;
      mis_q   <= 1'b0;
      win_q   <= '0;
      werr_q  <= '0;
    end else begin
      state_q <= state_d;
      inv_q   <= inv_d;
      seed_q  <= seed_d;
      chk_q   <= chk_d;
      hit_q   <= hit_d;
      mis_q   <= mis_d;
      win_q   <= win_d;
      werr_q  <= werr_d;
    end
  end

  assign state = state_q;
  assign inv   = inv_q;
endmodule

// File: rtl/prbs_autolock_checker.sv
module prbs_autolock_checker
  import prbs_chk_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int LOCK_LEN = 64,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       poly_sel_i,
  input  logic             bit_i,
  input  logic             valid_i,
  input  logic             blank_i,
  input  logic             resync_i,
  output logic             locked_o,
  output logic             inverted_o,
  output logic             err_o,
  output logic [CNT_W-1:0] bit_count_o,
  output logic [CNT_W-1:0] err_count_o
);
  logic              rst_meta, rst_sync;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              pred, miss, shift_in, in_lock, inv;
  logic              cnt_en, err_hit, err_q;
  sync_state_e       state;
  logic [1:0]        inc_vec;
  logic [CNT_W-1:0]  cnt_vec [2];

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  prbs_predict u_pred (.hist(hist_q), .sel(poly_sel_i), .pred(pred));

  prbs_sync_ctrl #(
    .LOCK_LEN(LOCK_LEN), .WIN_LEN(WIN_LEN), .LOSS_THR(LOSS_THR)
  ) u_sync (
    .clk(clk), .rst_n(rst_sync), .sel(poly_sel_i), .valid(valid_i),
    .miss(miss), .blank(blank_i), .resync(resync_i), .state(state), .inv(inv)
  );

  always_comb begin
    in_lock  = (state == ST_LOCK);
    miss     = bit_i ^ pred;
    // Once locked the generator runs on its own prediction, so a received error does not spread.
    shift_in = in_lock ? (pred ^ inv) : bit_i;
    hist_d   = valid_i ? {hist_q[HIST_W-2:0], shift_in} : hist_q;
    cnt_en   = valid_i & in_lock & ~blank_i & ~resync_i;
    err_hit  = cnt_en & (miss ^ inv);
    inc_vec  = {err_hit, cnt_en};
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      hist_q <= '0;
      err_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      err_q  <= err_hit;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_sync), .inc(inc_vec[g]), .count(cnt_vec[g])
    );
  end

  assign locked_o    = in_lock;
  assign inverted_o  = inv;
  assign err_o       = err_q;
  assign bit_count_o = cnt_vec[0];
  assign err_count_o = cnt_vec[1];
endmodule

// File: rtl/prbs_autolock_checker_props.sv
module prbs_autolock_checker_props #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic             blank_i,
  input logic             resync_i,
  input logic             locked_o,
  input logic             err_o,
  input logic [CNT_W-1:0] bit_count_o,
  input logic [CNT_W-1:0] err_count_o
);
  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(locked_o) && $past(valid_i) && !$past(blank_i))); // R5

  AST_ERR_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ((err_count_o == $past(err_count_o) + 1'b1) || (&err_count_o))); // R5

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> ($stable(bit_count_o) && $stable(err_count_o))); // R7

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(bit_count_o)); // R6

  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> !locked_o); // R8

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |=> ($stable(bit_count_o) && !err_o)); // R11

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (&bit_count_o) |=> (&bit_count_o)); // R10
endmodule

bind prbs_autolock_checker prbs_autolock_checker_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .blank_i(blank_i),
  .resync_i(resync_i), .locked_o(locked_o), .err_o(err_o),
  .bit_count_o(bit_count_o), .err_count_o(err_count_o)
);

// File: tb/sim_prbs_autolock_checker.sv
module sim_prbs_autolock_checker;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic din = 1'b0, vld = 1'b0, blk = 1'b0, rsy = 1'b0;
  logic locked, inverted, err;
  logic [CW-1:0] bcnt, ecnt;

  int n_tests = 0;
  int n_fail  = 0;

  logic [30:0] ghist;
  int          gdeg, gsec;
  logic        ginv;

  always #4 clk = ~clk;

  prbs_autolock_checker #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .poly_sel_i(sel), .bit_i(din), .valid_i(vld),
    .blank_i(blk), .resync_i(rsy), .locked_o(locked), .inverted_o(inverted),
    .err_o(err), .bit_count_o(bcnt), .err_count_o(ecnt)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference sequence: b[n] = b[n-deg] ^ b[n-sec].
  task automatic gen(output logic b);
    logic nb;
    nb    = ghist[gdeg-1] ^ ghist[gsec-1];
    ghist = {ghist[29:0], nb};
    b     = nb ^ ginv;
  endtask

  task automatic send(input logic b, input logic v, input logic bl);
    din = b; vld = v; blk = bl;
    @(negedge clk);
    vld = 1'b0; blk = 1'b0; rsy = 1'b0;
  endtask

  task automatic send_good(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin gen(b); send(b, 1'b1, 1'b0); end
  endtask

  task automatic send_bad(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin gen(b); send(~b, 1'b1, 1'b0); end
  endtask

  task automatic start(input logic [2:0] s, input logic inv);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sel = s; ginv = inv; ghist = '1;
    case (s)
      3'd1:    begin gdeg = 9;  gsec = 5;  end
      3'd2:    begin gdeg = 15; gsec = 14; end
      3'd3:    begin gdeg = 23; gsec = 18; end
      3'd4:    begin gdeg = 31; gsec = 28; end
      default: begin gdeg = 7;  gsec = 6;  end
    endcase
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic acquire();
    send_good(gdeg + 64);
  endtask

  task automatic t_reset();
    start(3'd0, 1'b0);
    check("R12 locked", locked, 0);
    check("R12 inverted", inverted, 0);
    check("R12 err", err, 0);
    check("R12 bit count", bcnt, 0);
    check("R12 err count", ecnt, 0);
  endtask

  task automatic t_lock_true();
    logic b;
    start(3'd0, 1'b0);
    send_good(7 + 63);
    check("R2 not yet locked", locked, 0);
    check("R11 no bits while unlocked", bcnt, 0);
    send_good(1);
    check("R2 locked", locked, 1);
    check("R3 true polarity", inverted, 0);
    for (int i = 0; i < 20; i++) begin
      gen(b);
      send(b, 1'b1, 1'b0);
      send(~b, 1'b0, 1'b0);
    end
    check("R6 bit count ignores invalid cycles", bcnt, 20);
    check("R6 no errors on clean stream", ecnt, 0);
  endtask

  task automatic t_error();
    start(3'd0, 1'b0);
    acquire();
    send_bad(1);
    check("R5 err strobe", err, 1);
    check("R5 err count", ecnt, 1);
    send_good(1);
    check("R5 strobe lasts one cycle", err, 0);
    check("R5 err count holds", ecnt, 1);
  endtask

  task automatic t_blank();
    logic b;
    start(3'd0, 1'b0);
    acquire();
    gen(b);
    send(~b, 1'b1, 1'b1);
    check("R7 no strobe when blanked", err, 0);
    check("R7 err count when blanked", ecnt, 0);
    check("R7 bit count when blanked", bcnt, 0);
    send_good(1);
    check("R7 counting resumes", bcnt, 1);
  endtask

  task automatic t_inverted();
    start(3'd2, 1'b1);
    acquire();
    check("R3 inverted lock", locked, 1);
    check("R3 inverted flag", inverted, 1);
    send_good(10);
    check("R3 complement expected", ecnt, 0);
    send_bad(1);
    check("R3 error on inverted stream", ecnt, 1);
  endtask

  task automatic t_polys();
    for (int s = 0; s < 5; s++) begin
      start(3'(s), s[0]);
      acquire();
      check($sformatf("R1 lock sel=%0d", s), locked, 1);
      check($sformatf("R1 polarity sel=%0d", s), inverted, s[0]);
    end
  endtask

  task automatic t_nolock();
    start(3'd0, 1'b0);
    for (int i = 0; i < 300; i++) send((i % 3) != 2, 1'b1, 1'b0);
    check("R4 no lock on foreign stream", locked, 0);
    check("R11 no bits counted", bcnt, 0);
  endtask

  task automatic t_loss();
    start(3'd0, 1'b0);
    acquire();
    send_bad(15);
    check("R9 15 errors keep lock", locked, 1);
    send_good(49);
    send_bad(15);
    check("R9 window restarts after 64 bits", locked, 1);
    start(3'd0, 1'b0);
    acquire();
    send_bad(15);
    check("R9 still locked before 16th", locked, 1);
    send_bad(1);
    check("R9 16th error drops lock", locked, 0);
    check("R9 err count at loss", ecnt, 16);
  endtask

  task automatic t_resync();
    logic b;
    start(3'd4, 1'b0);
    acquire();
    gen(b);
    rsy = 1'b1;
    send(b, 1'b1, 1'b0);
    check("R8 resync drops lock", locked, 0);
    send_good(31 + 64);
    check("R8 relock after resync", locked, 1);
  endtask

  task automatic t_saturate();
    logic b;
    start(3'd0, 1'b0);
    acquire();
    for (int i = 0; i < 600; i++) begin
      gen(b);
      send(((i % 8) == 0) ? ~b : b, 1'b1, 1'b0);
    end
    check("R10 lock kept at 8 errors per window", locked, 1);
    check("R10 bit count saturates", bcnt, 63);
    check("R10 err count saturates", ecnt, 63);
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_true();
    t_error();
    t_blank();
    t_inverted();
    t_polys();
    t_nolock();
    t_loss();
    t_resync();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule